// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the in-order view of an out-of-order core that runs ahead on predicted branches. Each instruction leaving issue claims one entry at the tail of a circular buffer and receives that entry's index as its tag. Functional units later broadcast a result together with the tag on a shared result bus. The buffer stores the result in the tagged entry and marks the entry complete. Until then, nothing architectural has changed. Issue logic can look up any tag to read a completed result directly, without going through the register file.

Entries leave the buffer only from the head, in program order, at a rate of up to two per clock. A register operation that retires produces a register-file write. A store produces a memory write: the address is the one given at issue and the data is the value delivered on the bus. A correctly predicted branch simply retires. A branch that was resolved as mispredicted, or any entry that reported a fault during execution, has no effect while it is younger than the head. Once it becomes the head, the buffer discards every entry and raises either a fetch redirect or an exception pulse.

Top module: `spec_rob`

## Requirements
- R1: An issue is accepted when `iss_valid` and `iss_ready` are both high. The accepted instruction takes the tag shown on `iss_tag` in that cycle. Tags are handed out consecutively, wrap from DEPTH-1 to 0, and restart at 0 after reset or after a flush.
- R2: When all DEPTH entries are occupied, `iss_ready` is low and `iss_valid` has no effect: no entry is claimed and `iss_tag` does not move. `iss_ready` returns high once entries retire.
- R3: A bus pulse (`cdb_valid`) with a live tag stores `cdb_value` in that entry and marks it complete. From the next cycle on, a lookup of that tag on `rd_tag` returns `rd_hit`=1 and the stored value. A lookup of an entry that is not yet complete returns `rd_hit`=0.
- R4: After reset, `iss_ready` is 1, `iss_tag` is 0, and every write, redirect and exception output is 0.
- R5: Only the head can retire, and only once it is complete. A complete entry behind an incomplete head produces no output.
- R6: The issue kind selects the retire action: 0 is a register operation, 1 is a store, 2 is a branch. Retiring a kind-0 entry pulses `cN_rf_we` with `cN_dest` set to the register number and `cN_data` set to the result. Retiring a kind-1 entry pulses `cN_mem_we` with `cN_dest` set to the address and `cN_data` set to the store data. A correct branch retires with no write. Each of these outputs appears one clock after the edge at which the entry was the complete head.
- R7: Two entries retire in the same clock when the head and the entry after it are both complete and neither is faulting. The head always uses slot 0 and the younger entry uses slot 1. A faulting entry never takes slot 1.
- R8: A kind-2 entry that completed with `cdb_mispred`=1 flushes all entries when it is the head. The flush gives a one-cycle `redir_valid` with `redir_pc` equal to the branch's bus value, and no write from either slot. `iss_ready` is low in the flush cycle.
- R9: An entry that completed with `cdb_exc`=1 causes no action while older entries are still present. Older entries retire normally. When the faulting entry is the head, a one-cycle `exc_valid` is raised, every entry is flushed, and neither it nor any younger entry writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | 0 register op, 1 store, 2 branch |
| iss_dest | input | DEST_W | Register number or store address |
| iss_ready | output | 1 | Free entry available and no flush this cycle |
| iss_tag | output | TAG_W | Tag for the instruction issued this cycle |
| cdb_valid | input | 1 | Result bus pulse |
| cdb_tag | input | TAG_W | Entry the result belongs to |
| cdb_value | input | DATA_W | Result, store data or correct branch target |
| cdb_exc | input | 1 | Execution raised a fault |
| cdb_mispred | input | 1 | Branch resolved against its prediction |
| rd_tag | input | TAG_W | Operand lookup tag |
| rd_hit | output | 1 | Looked-up entry is complete |
| rd_value | output | DATA_W | Looked-up entry's value |
| c0_rf_we | output | 1 | Slot 0 register write |
| c0_mem_we | output | 1 | Slot 0 memory write |
| c0_dest | output | DEST_W | Slot 0 register number or address |
| c0_data | output | DATA_W | Slot 0 data |
| c1_rf_we | output | 1 | Slot 1 register write |
| c1_mem_we | output | 1 | Slot 1 memory write |
| c1_dest | output | DEST_W | Slot 1 register number or address |
| c1_data | output | DATA_W | Slot 1 data |
| redir_valid | output | 1 | Mispredict redirect pulse |
| redir_pc | output | DATA_W | Correct successor address |
| exc_valid | output | 1 | Deferred exception pulse |

## Verification
The embedded properties are checked on every clock. They cover the following: occupancy never exceeds DEPTH, the tag advances by one with wrap on each accepted issue, allocation always lands on a free entry, and bus results only target live entries. They also cover that a flush empties the buffer on the next cycle, that a redirect or exception never coincides with an architectural write, and that a redirect lasts one cycle. The scenarios alone show what data reaches the outputs and in what order. That includes in-order retirement behind a late head, pairing into two slots, stalling when full, the deferral of mispredicts and faults until they reach the head, and the restart of tags at zero.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_REG    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2
  } kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [1:0]       ret_n,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] head_nx,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [TAG_W-1:0] head_q, tail_q, head_after;
  logic [CNT_W-1:0] count_q;

  always_comb begin
    head_after = head_q;
    if (ret_n == 2'd1) head_after = bump(head_q);
    else if (ret_n == 2'd2) head_after = bump(bump(head_q));
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_after;
      if (alloc_en) tail_q <= bump(tail_q);
      count_q <= count_q + CNT_W'(alloc_en) - CNT_W'(ret_n);
    end
  end

  assign head    = head_q;
  assign head_nx = bump(head_q);
  assign tail    = tail_q;
  assign count   = count_q;
  assign full    = (count_q == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count_q == '0)); // R8
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              alloc_en,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  kind_e             alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              cdb_en,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              cdb_exc,
  input  logic              cdb_mispred,
  input  logic              free0_en,
  input  logic              free1_en,
  input  logic [TAG_W-1:0]  h0_tag,
  input  logic [TAG_W-1:0]  h1_tag,
  output logic              h0_valid,
  output logic              h0_ready,
  output kind_e             h0_kind,
  output logic [DEST_W-1:0] h0_dest,
  output logic [DATA_W-1:0] h0_value,
  output logic              h0_exc,
  output logic              h0_mis,
  output logic              h1_valid,
  output logic              h1_ready,
  output kind_e             h1_kind,
  output logic [DEST_W-1:0] h1_dest,
  output logic [DATA_W-1:0] h1_value,
  output logic              h1_exc,
  output logic              h1_mis,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_value
);
  logic              live_q [DEPTH];
  logic              done_q [DEPTH];
  logic              exc_q  [DEPTH];
  logic              mis_q  [DEPTH];
  kind_e             kind_m [DEPTH];
  logic [DEST_W-1:0] dest_m [DEPTH];
  logic [DATA_W-1:0] val_m  [DEPTH];

  // status flags need reset and flush clear; one register set per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit_alloc, hit_cdb, hit_free;
    assign hit_alloc = alloc_en && (alloc_tag == TAG_W'(i));
    assign hit_cdb   = cdb_en && (cdb_tag == TAG_W'(i)) && live_q[i];
    assign hit_free  = (free0_en && (h0_tag == TAG_W'(i))) ||
                       (free1_en && (h1_tag == TAG_W'(i)));
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        live_q[i] <= 1'b0;
        done_q[i] <= 1'b0;
        exc_q[i]  <= 1'b0;
        mis_q[i]  <= 1'b0;
      end else if (hit_alloc) begin
        live_q[i] <= 1'b1;
        done_q[i] <= 1'b0;
        exc_q[i]  <= 1'b0;
        mis_q[i]  <= 1'b0;
      end else if (hit_free) begin
        live_q[i] <= 1'b0;
        done_q[i] <= 1'b0;
      end else if (hit_cdb) begin
        done_q[i] <= 1'b1;
        exc_q[i]  <= cdb_exc;
        mis_q[i]  <= cdb_mispred;
      end
    end
  end

  // payload arrays: single write port each, no reset
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      kind_m[alloc_tag] <= alloc_kind;
      dest_m[alloc_tag] <= alloc_dest;
    end
    if (cdb_en) val_m[cdb_tag] <= cdb_value;
  end

  assign h0_valid = live_q[h0_tag];
  assign h0_ready = done_q[h0_tag];
  assign h0_kind  = kind_m[h0_tag];
  assign h0_dest  = dest_m[h0_tag];
  assign h0_value = val_m[h0_tag];
  assign h0_exc   = exc_q[h0_tag];
  assign h0_mis   = mis_q[h0_tag];
  assign h1_valid = live_q[h1_tag];
  assign h1_ready = done_q[h1_tag];
  assign h1_kind  = kind_m[h1_tag];
  assign h1_dest  = dest_m[h1_tag];
  assign h1_value = val_m[h1_tag];
  assign h1_exc   = exc_q[h1_tag];
  assign h1_mis   = mis_q[h1_tag];
  assign rd_hit   = live_q[rd_tag] && done_q[rd_tag];
  assign rd_value = val_m[rd_tag];

  AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> !live_q[alloc_tag]); // R1
  AST_CDB_LIVE: assert property (@(posedge clk) disable iff (rst)
    (cdb_en && !flush) |-> live_q[cdb_tag]); // R3
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEST_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h0_valid,
  input  logic              h0_ready,
  input  kind_e             h0_kind,
  input  logic [DEST_W-1:0] h0_dest,
  input  logic [DATA_W-1:0] h0_value,
  input  logic              h0_exc,
  input  logic              h0_mis,
  input  logic              h1_valid,
  input  logic              h1_ready,
  input  kind_e             h1_kind,
  input  logic [DEST_W-1:0] h1_dest,
  input  logic [DATA_W-1:0] h1_value,
  input  logic              h1_exc,
  input  logic              h1_mis,
  output logic              free0_en,
  output logic              free1_en,
  output logic [1:0]        ret_n,
  output logic              flush_now,
  output logic              c0_rf_we,
  output logic              c0_mem_we,
  output logic [DEST_W-1:0] c0_dest,
  output logic [DATA_W-1:0] c0_data,
  output logic              c1_rf_we,
  output logic              c1_mem_we,
  output logic [DEST_W-1:0] c1_dest,
  output logic [DATA_W-1:0] c1_data,
  output logic              redir_valid,
  output logic [DATA_W-1:0] redir_pc,
  output logic              exc_valid
);
  logic go0, fault0, ok0, fault1, ok1;

  always_comb begin
    go0    = h0_valid && h0_ready;
    fault0 = h0_exc || ((h0_kind == K_BRANCH) && h0_mis);
    ok0    = go0 && !fault0;
    fault1 = h1_exc || ((h1_kind == K_BRANCH) && h1_mis);
    ok1    = ok0 && h1_valid && h1_ready && !fault1;
  end

  assign free0_en  = ok0;
  assign free1_en  = ok1;
  assign ret_n     = {1'b0, ok0} + {1'b0, ok1};
  assign flush_now = go0 && fault0;

  always_ff @(posedge clk) begin
    if (rst) begin
      c0_rf_we    <= 1'b0;
      c0_mem_we   <= 1'b0;
      c0_dest     <= '0;
      c0_data     <= '0;
      c1_rf_we    <= 1'b0;
      c1_mem_we   <= 1'b0;
      c1_dest     <= '0;
      c1_data     <= '0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      exc_valid   <= 1'b0;
    end else begin
      c0_rf_we    <= ok0 && (h0_kind == K_REG);
      c0_mem_we   <= ok0 && (h0_kind == K_STORE);
      c0_dest     <= h0_dest;
      c0_data     <= h0_value;
      c1_rf_we    <= ok1 && (h1_kind == K_REG);
      c1_mem_we   <= ok1 && (h1_kind == K_STORE);
      c1_dest     <= h1_dest;
      c1_data     <= h1_value;
      redir_valid <= flush_now && !h0_exc;
      redir_pc    <= h0_value;
      exc_valid   <= flush_now && h0_exc;
    end
  end
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [1:0]        iss_kind,
  input  logic [DEST_W-1:0] iss_dest,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              cdb_exc,
  input  logic              cdb_mispred,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_value,
  output logic              c0_rf_we,
  output logic              c0_mem_we,
  output logic [DEST_W-1:0] c0_dest,
  output logic [DATA_W-1:0] c0_data,
  output logic              c1_rf_we,
  output logic              c1_mem_we,
  output logic [DEST_W-1:0] c1_dest,
  output logic [DATA_W-1:0] c1_data,
  output logic              redir_valid,
  output logic [DATA_W-1:0] redir_pc,
  output logic              exc_valid
);
  logic [TAG_W-1:0]  head, head_nx, tail;
  logic [CNT_W-1:0]  count;
  logic              full, flush_now, alloc_en, free0_en, free1_en;
  logic [1:0]        ret_n;
  logic              h0_valid, h0_ready, h0_exc, h0_mis;
  logic              h1_valid, h1_ready, h1_exc, h1_mis;
  kind_e             h0_kind, h1_kind;
  logic [DEST_W-1:0] h0_dest, h1_dest;
  logic [DATA_W-1:0] h0_value, h1_value;

  assign iss_ready = !full && !flush_now;
  assign alloc_en  = iss_valid && iss_ready;
  assign iss_tag   = tail;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .alloc_en(alloc_en), .ret_n(ret_n), .flush(flush_now),
    .head(head), .head_nx(head_nx), .tail(tail), .count(count), .full(full)
  );

  rob_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush_now),
    .alloc_en(alloc_en), .alloc_tag(tail), .alloc_kind(kind_e'(iss_kind)),
    .alloc_dest(iss_dest),
    .cdb_en(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .cdb_exc(cdb_exc), .cdb_mispred(cdb_mispred),
    .free0_en(free0_en), .free1_en(free1_en), .h0_tag(head), .h1_tag(head_nx),
    .h0_valid(h0_valid), .h0_ready(h0_ready), .h0_kind(h0_kind), .h0_dest(h0_dest),
    .h0_value(h0_value), .h0_exc(h0_exc), .h0_mis(h0_mis),
    .h1_valid(h1_valid), .h1_ready(h1_ready), .h1_kind(h1_kind), .h1_dest(h1_dest),
    .h1_value(h1_value), .h1_exc(h1_exc), .h1_mis(h1_mis),
    .rd_tag(rd_tag), .rd_hit(rd_hit), .rd_value(rd_value)
  );

  rob_retire #(.DATA_W(DATA_W), .DEST_W(DEST_W)) u_retire (
    .clk(clk), .rst(rst),
    .h0_valid(h0_valid), .h0_ready(h0_ready), .h0_kind(h0_kind), .h0_dest(h0_dest),
    .h0_value(h0_value), .h0_exc(h0_exc), .h0_mis(h0_mis),
    .h1_valid(h1_valid), .h1_ready(h1_ready), .h1_kind(h1_kind), .h1_dest(h1_dest),
    .h1_value(h1_value), .h1_exc(h1_exc), .h1_mis(h1_mis),
    .free0_en(free0_en), .free1_en(free1_en), .ret_n(ret_n), .flush_now(flush_now),
    .c0_rf_we(c0_rf_we), .c0_mem_we(c0_mem_we), .c0_dest(c0_dest), .c0_data(c0_data),
    .c1_rf_we(c1_rf_we), .c1_mem_we(c1_mem_we), .c1_dest(c1_dest), .c1_data(c1_data),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .exc_valid(exc_valid)
  );

  AST_TAG_STEP: assert property (@(posedge clk) disable iff (rst)
    (alloc_en && !flush_now) |=>
      (iss_tag == (($past(iss_tag) == TAG_W'(DEPTH - 1)) ? '0 : $past(iss_tag) + 1'b1))); // R1
  AST_QUIET_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (redir_valid || exc_valid) |-> !(c0_rf_we || c0_mem_we || c1_rf_we || c1_mem_we)); // R8
  AST_REDIR_PULSE: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !redir_valid); // R8
  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (rst)
    (c1_rf_we || c1_mem_we) |-> !(redir_valid || exc_valid)); // R7
endmodule

// File: tb/sim_spec_rob.sv
module sim_spec_rob;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;
  localparam int TW    = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic iss_valid = 1'b0;
  logic [1:0] iss_kind = '0;
  logic [31:0] iss_dest = '0;
  logic iss_ready;
  logic [TW-1:0] iss_tag;
  logic cdb_valid = 1'b0, cdb_exc = 1'b0, cdb_mispred = 1'b0;
  logic [TW-1:0] cdb_tag = '0, rd_tag = '0;
  logic [31:0] cdb_value = '0;
  logic rd_hit;
  logic [31:0] rd_value;
  logic c0_rf_we, c0_mem_we, c1_rf_we, c1_mem_we, redir_valid, exc_valid;
  logic [31:0] c0_dest, c0_data, c1_dest, c1_data, redir_pc;

  spec_rob #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_dest(iss_dest),
    .iss_ready(iss_ready), .iss_tag(iss_tag), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_value(cdb_value), .cdb_exc(cdb_exc), .cdb_mispred(cdb_mispred),
    .rd_tag(rd_tag), .rd_hit(rd_hit), .rd_value(rd_value),
    .c0_rf_we(c0_rf_we), .c0_mem_we(c0_mem_we), .c0_dest(c0_dest), .c0_data(c0_data),
    .c1_rf_we(c1_rf_we), .c1_mem_we(c1_mem_we), .c1_dest(c1_dest), .c1_data(c1_data),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .exc_valid(exc_valid)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0, ev_n = 0;
  int ev_k [64];   // 0 reg write, 1 mem write, 2 redirect, 3 exception
  int ev_s [64];
  int ev_c [64];
  logic [31:0] ev_a [64];
  logic [31:0] ev_d [64];

  function automatic void log_ev(int k, int s, logic [31:0] a, logic [31:0] d);
    if (ev_n < 64) begin
      ev_k[ev_n] = k; ev_s[ev_n] = s; ev_c[ev_n] = cyc; ev_a[ev_n] = a; ev_d[ev_n] = d;
      ev_n++;
    end
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (c0_rf_we)    log_ev(0, 0, c0_dest, c0_data);
      if (c0_mem_we)   log_ev(1, 0, c0_dest, c0_data);
      if (c1_rf_we)    log_ev(0, 1, c1_dest, c1_data);
      if (c1_mem_we)   log_ev(1, 1, c1_dest, c1_data);
      if (redir_valid) log_ev(2, 0, 32'd0, redir_pc);
      if (exc_valid)   log_ev(3, 0, 32'd0, 32'd0);
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_issue(input logic [1:0] k, input logic [31:0] d, output logic [TW-1:0] t);
    @(negedge clk);
    chk(iss_ready == 1'b1, "R2 ready before issue", iss_ready, 1);
    iss_valid = 1'b1; iss_kind = k; iss_dest = d;
    t = iss_tag;
    @(posedge clk); #1;
    iss_valid = 1'b0;
  endtask

  task automatic do_cdb(input logic [TW-1:0] t, input logic [31:0] v, input bit e, input bit m);
    @(negedge clk);
    cdb_valid = 1'b1; cdb_tag = t; cdb_value = v; cdb_exc = e; cdb_mispred = m;
    @(posedge clk); #1;
    cdb_valid = 1'b0; cdb_exc = 1'b0; cdb_mispred = 1'b0;
  endtask

  task automatic chk_ev(input int i, input int k, input int s, input logic [31:0] a,
                        input logic [31:0] d, input string req);
    chk(ev_k[i] == k && ev_s[i] == s, {req, " event kind/slot"}, {ev_k[i][15:0], ev_s[i][15:0]},
        {k[15:0], s[15:0]});
    chk(ev_a[i] == a && ev_d[i] == d, {req, " event addr/data"}, {ev_a[i], ev_d[i]}, {a, d});
  endtask

  task automatic t_reset();
    settle(1);
    chk(iss_ready == 1'b1, "R4 iss_ready after reset", iss_ready, 1);
    chk(iss_tag == '0, "R4 iss_tag after reset", iss_tag, 0);
    chk({c0_rf_we, c0_mem_we, c1_rf_we, c1_mem_we, redir_valid, exc_valid} == '0,
        "R4 outputs idle", {c0_rf_we, c0_mem_we, c1_rf_we, c1_mem_we, redir_valid, exc_valid}, 0);
  endtask

  task automatic t_basic();
    logic [TW-1:0] ta, tb, tc;
    int b;
    b = ev_n;
    do_issue(2'd0, 32'd3, ta);
    do_issue(2'd1, 32'h100, tb);
    do_issue(2'd2, 32'd0, tc);
    chk(ta == 0 && tb == 1 && tc == 2, "R1 consecutive tags", {ta, tb, tc}, {3'd0, 3'd1, 3'd2});
    rd_tag = tc; #1;
    chk(rd_hit == 1'b0, "R3 lookup before result", rd_hit, 0);
    do_cdb(tc, 32'h40, 1'b0, 1'b0);
    do_cdb(tb, 32'hBEEF, 1'b0, 1'b0);
    settle(2);
    chk(ev_n == b, "R5 no retire behind incomplete head", ev_n - b, 0);
    rd_tag = tc; #1;
    chk(rd_hit == 1'b1 && rd_value == 32'h40, "R3 lookup after result", {rd_hit, rd_value}, {1'b1, 32'h40});
    rd_tag = ta; #1;
    chk(rd_hit == 1'b0, "R3 lookup of pending entry", rd_hit, 0);
    do_cdb(ta, 32'h11, 1'b0, 1'b0);
    settle(3);
    chk(ev_n - b == 2, "R6 correct branch writes nothing", ev_n - b, 2);
    chk_ev(b, 0, 0, 32'd3, 32'h11, "R6 register retire");
    chk_ev(b + 1, 1, 1, 32'h100, 32'hBEEF, "R6 store retire");
    chk(ev_c[b] == ev_c[b + 1], "R7 pair retires together", ev_c[b + 1], ev_c[b]);
    chk(iss_tag == 3'd3, "R1 tag after three issues", iss_tag, 3);
  endtask

  task automatic t_full();
    logic [TW-1:0] t [DEPTH];
    int b;
    b = ev_n;
    for (int i = 0; i < DEPTH; i++) begin
      do_issue(2'd0, 32'(i), t[i]);
      chk(t[i] == TW'((3 + i) % DEPTH), "R1 wrapping tag", t[i], (3 + i) % DEPTH);
    end
    settle(0);
    chk(iss_ready == 1'b0, "R2 full stalls issue", iss_ready, 0);
    @(negedge clk);
    iss_valid = 1'b1; iss_kind = 2'd0; iss_dest = 32'd30;
    @(posedge clk); #1;
    iss_valid = 1'b0;
    chk(iss_tag == 3'd3 && iss_ready == 1'b0, "R2 issue ignored while full", {iss_ready, iss_tag}, {1'b0, 3'd3});
    for (int i = 0; i < DEPTH; i++) do_cdb(t[i], 32'h200 + 32'(i), 1'b0, 1'b0);
    settle(3);
    chk(ev_n - b == DEPTH, "R5 all entries retire", ev_n - b, DEPTH);
    for (int i = 0; i < DEPTH; i++)
      chk(ev_k[b + i] == 0 && ev_a[b + i] == 32'(i) && ev_d[b + i] == 32'h200 + 32'(i),
          "R5 program order", {ev_a[b + i], ev_d[b + i]}, {32'(i), 32'h200 + 32'(i)});
    chk(iss_ready == 1'b1 && iss_tag == 3'd3, "R2 ready after drain", {iss_ready, iss_tag}, {1'b1, 3'd3});
  endtask

  task automatic t_late_head();
    logic [TW-1:0] tx, ty;
    int b;
    b = ev_n;
    do_issue(2'd0, 32'd9, tx);
    do_issue(2'd0, 32'd10, ty);
    do_cdb(ty, 32'h77, 1'b0, 1'b0);
    settle(3);
    chk(ev_n == b, "R5 younger waits for head", ev_n - b, 0);
    do_cdb(tx, 32'h66, 1'b0, 1'b0);
    settle(3);
    chk(ev_n - b == 2, "R7 two retires", ev_n - b, 2);
    chk_ev(b, 0, 0, 32'd9, 32'h66, "R7 head in slot 0");
    chk_ev(b + 1, 0, 1, 32'd10, 32'h77, "R7 next in slot 1");
  endtask

  task automatic t_mispredict();
    logic [TW-1:0] tp, tq, tr;
    int b;
    b = ev_n;
    do_issue(2'd0, 32'd4, tp);
    do_issue(2'd2, 32'd0, tq);
    do_issue(2'd0, 32'd5, tr);
    do_cdb(tr, 32'h55, 1'b0, 1'b0);
    do_cdb(tq, 32'h800, 1'b0, 1'b1);
    settle(2);
    chk(ev_n == b, "R8 mispredict waits for head", ev_n - b, 0);
    do_cdb(tp, 32'h44, 1'b0, 1'b0);
    settle(4);
    chk(ev_n - b == 2, "R8 only older write plus redirect", ev_n - b, 2);
    chk_ev(b, 0, 0, 32'd4, 32'h44, "R8 older entry retires");
    chk_ev(b + 1, 2, 0, 32'd0, 32'h800, "R8 redirect target");
    chk(ev_c[b + 1] == ev_c[b] + 1, "R7 faulting entry not paired", ev_c[b + 1], ev_c[b] + 1);
    rd_tag = tr; #1;
    chk(rd_hit == 1'b0, "R8 younger entry flushed", rd_hit, 0);
    chk(iss_tag == '0 && iss_ready == 1'b1, "R8 tags restart at zero", {iss_ready, iss_tag}, {1'b1, 3'd0});
  endtask

  task automatic t_exception();
    logic [TW-1:0] ts, tt, tu;
    int b;
    b = ev_n;
    do_issue(2'd1, 32'h300, ts);
    do_issue(2'd0, 32'd6, tt);
    do_issue(2'd0, 32'd7, tu);
    do_cdb(tu, 32'd1, 1'b0, 1'b0);
    do_cdb(tt, 32'd2, 1'b1, 1'b0);
    settle(2);
    chk(ev_n == b, "R9 fault deferred", ev_n - b, 0);
    do_cdb(ts, 32'hCAFE, 1'b0, 1'b0);
    settle(4);
    chk(ev_n - b == 2, "R9 store then exception only", ev_n - b, 2);
    chk_ev(b, 1, 0, 32'h300, 32'hCAFE, "R9 older store retires");
    chk(ev_k[b + 1] == 3, "R9 exception pulse", ev_k[b + 1], 3);
    chk(iss_tag == '0, "R9 flush restarts tags", iss_tag, 0);
  endtask

  task automatic t_restart();
    logic [TW-1:0] tv;
    int b;
    b = ev_n;
    do_issue(2'd0, 32'd12, tv);
    chk(tv == '0, "R1 first tag after flush", tv, 0);
    do_cdb(tv, 32'h5A, 1'b0, 1'b0);
    settle(3);
    chk(ev_n - b == 1, "R6 retire after flush", ev_n - b, 1);
    chk_ev(b, 0, 0, 32'd12, 32'h5A, "R6 register retire after flush");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_basic();
    t_full();
    t_late_head();
    t_mispredict();
    t_exception();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule